// File: doc/BRIEF.md
# Producer-Tag Register File

This block is the architectural register file of an out-of-order core that renames through reservation-station tags. Each register holds a data word and a producer tag. A tag of zero means that the data word is the register's current value. A nonzero tag names the in-flight operation that will produce the next value. When the issue stage dispatches an instruction, it stamps that instruction's tag into the destination register.

The file watches the result broadcast bus on every cycle. Any register whose pending tag equals the tag being broadcast takes the broadcast data on the next clock edge and returns its tag to zero. Two combinational read ports give the issue stage both the value and the tag of a register. The issue stage can then pass a reservation station either a ready operand or the tag it must wait for. If a read hits a register whose pending tag is being broadcast in that same cycle, the read returns the broadcast value as ready, so no operand is lost in that window. Register 0 is hardwired to zero.

Top module: `tag_rf`

## Requirements
- R1: After reset, every register reads as data 0 with tag 0.
- R2: In a cycle where `iss_we` is 1, `iss_tag` is nonzero and `iss_addr` is not 0, the addressed register's tag becomes `iss_tag` at the next clock edge. If there is no same-cycle capture, its data is unchanged.
- R3: When `cdb_valid` is 1 and `cdb_tag` is nonzero, every register (other than 0) whose tag equals `cdb_tag` loads `cdb_data` at the next edge. Each such register's tag becomes 0 unless R7 applies.
- R4: A broadcast has no effect on a register if `cdb_valid` is 0, if `cdb_tag` is 0, or if the register's tag differs from `cdb_tag`.
- R5: A read of register k (k not 0) with no bypass returns that register's stored data and stored tag in the same cycle. A returned tag of 0 marks the data as ready.
- R6: If `cdb_valid` is 1, `cdb_tag` is nonzero and it equals register k's stored tag, a read of k returns `cdb_data` with tag 0 in that same cycle.
- R7: If an issue write and a matching broadcast hit the same register in one cycle, the register ends with the new issue tag and with `cdb_data` as its data.
- R8: Register 0 ignores issue writes and broadcasts, and it always reads as data 0 with tag 0.
- R9: An issue write whose `iss_tag` is 0 changes nothing.
- R10: The two read ports are independent. Each applies R5, R6 and R8 to its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_we | input | 1 | Issue stage stamps a producer tag |
| iss_addr | input | 5 | Destination register of the issued instruction |
| iss_tag | input | 9 | Producer tag to stamp (0 = no-op) |
| cdb_valid | input | 1 | Broadcast bus carries a result |
| cdb_tag | input | 9 | Tag of the broadcast result |
| cdb_data | input | 32 | Broadcast result value |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A value |
| rd_tag_a | output | 9 | Read port A pending tag (0 = ready) |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B value |
| rd_tag_b | output | 9 | Read port B pending tag (0 = ready) |

## Verification
The bench builds the block with its default parameters: 32 registers, 32-bit data and 9-bit tags. At that size every register can be stamped, bypassed, captured and read back through both ports, so sweeping all addresses stays cheap. The sweeps also reach the top tag values and the case where two registers share one pending tag. Directed cycles cover the same-cycle collision between a new tag and a matching broadcast, zero-tag issues and broadcasts, and register 0.

// File: rtl/tag_rf_pkg.sv
package tag_rf_pkg;
  // Where a read port takes its value from
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_STORED = 2'd1,
    SRC_BYPASS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/tag_rf_entry.sv
// One architectural register: a data word plus its pending-producer tag.
module tag_rf_entry #(
  parameter int DW = 32,
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retag,
  input  logic [TW-1:0] new_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_data,
  output logic [DW-1:0] data_q,
  output logic [TW-1:0] tag_q,
  output logic          hit
);
  // A zero tag never names a producer, so it can never match.
  function automatic logic snoop_match(input logic v, input logic [TW-1:0] bus_tag,
                                       input logic [TW-1:0] own_tag);
    return v && (bus_tag != '0) && (bus_tag == own_tag);
  endfunction

  assign hit = snoop_match(cdb_valid, cdb_tag, tag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tag_q  <= '0;
    end else begin
      if (hit) data_q <= cdb_data;
      if (retag)    tag_q <= new_tag;   // newest producer takes precedence
      else if (hit) tag_q <= '0;
    end
  end
endmodule

// File: rtl/tag_rf_read.sv
// Combinational read port with same-cycle broadcast bypass.
module tag_rf_read
  import tag_rf_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  parameter int TW    = 9,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic [AW-1:0]             addr,
  input  logic [NREGS-1:0][DW-1:0]  data_all,
  input  logic [NREGS-1:0][TW-1:0]  tag_all,
  input  logic [NREGS-1:0]          hit_all,
  input  logic [DW-1:0]             cdb_data,
  output logic [DW-1:0]             rd_data,
  output logic [TW-1:0]             rd_tag
);
  rd_src_e src;

  always_comb begin
    if (addr == '0)        src = SRC_ZERO;
    else if (hit_all[addr]) src = SRC_BYPASS;
    else                   src = SRC_STORED;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO:   begin rd_data = '0;             rd_tag = '0;            end
      SRC_BYPASS: begin rd_data = cdb_data;       rd_tag = '0;            end
      default:    begin rd_data = data_all[addr]; rd_tag = tag_all[addr]; end
    endcase
  end
endmodule

// File: rtl/tag_rf.sv
// Register file whose entries are written by matching broadcast tags.
module tag_rf #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  parameter int TW    = 9,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_we,
  input  logic [AW-1:0] iss_addr,
  input  logic [TW-1:0] iss_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_data,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  output logic [TW-1:0] rd_tag_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  output logic [TW-1:0] rd_tag_b
);
  // Named internal events, visible to the bound checker
  logic [NREGS-1:0][DW-1:0] data_q;
  logic [NREGS-1:0][TW-1:0] tag_q;
  logic [NREGS-1:0]         snoop_hit;
  logic [NREGS-1:0]         retag_sel;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign data_q[i]    = '0;
      assign tag_q[i]     = '0;
      assign snoop_hit[i] = 1'b0;
      assign retag_sel[i] = 1'b0;
    end else begin : g_live
      assign retag_sel[i] = iss_we && (iss_tag != '0) && (iss_addr == AW'(i));
      tag_rf_entry #(.DW(DW), .TW(TW)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .retag     (retag_sel[i]),
        .new_tag   (iss_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_data  (cdb_data),
        .data_q    (data_q[i]),
        .tag_q     (tag_q[i]),
        .hit       (snoop_hit[i])
      );
    end
  end

  tag_rf_read #(.NREGS(NREGS), .DW(DW), .TW(TW)) u_rd_a (
    .addr (rd_addr_a), .data_all (data_q), .tag_all (tag_q), .hit_all (snoop_hit),
    .cdb_data (cdb_data), .rd_data (rd_data_a), .rd_tag (rd_tag_a)
  );

  tag_rf_read #(.NREGS(NREGS), .DW(DW), .TW(TW)) u_rd_b (
    .addr (rd_addr_b), .data_all (data_q), .tag_all (tag_q), .hit_all (snoop_hit),
    .cdb_data (cdb_data), .rd_data (rd_data_b), .rd_tag (rd_tag_b)
  );
endmodule

// File: rtl/tag_rf_chk.sv
module tag_rf_chk #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  parameter int TW    = 9,
  localparam int AW   = $clog2(NREGS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     iss_we,
  input logic [AW-1:0]            iss_addr,
  input logic [TW-1:0]            iss_tag,
  input logic                     cdb_valid,
  input logic [TW-1:0]            cdb_tag,
  input logic [DW-1:0]            cdb_data,
  input logic [AW-1:0]            rd_addr_a,
  input logic [DW-1:0]            rd_data_a,
  input logic [TW-1:0]            rd_tag_a,
  input logic [AW-1:0]            rd_addr_b,
  input logic [DW-1:0]            rd_data_b,
  input logic [TW-1:0]            rd_tag_b,
  input logic [NREGS-1:0][DW-1:0] data_q,
  input logic [NREGS-1:0][TW-1:0] tag_q,
  input logic [NREGS-1:0]         snoop_hit,
  input logic [NREGS-1:0]         retag_sel
);
  logic bcast_live;
  assign bcast_live = cdb_valid && (cdb_tag != '0);

  for (genvar i = 1; i < NREGS; i++) begin : g_cell
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_hit[i] |=> data_q[i] == $past(cdb_data));
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_hit[i] && !retag_sel[i] |=> tag_q[i] == '0);
    a_r7_new_tag_wins: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_hit[i] && retag_sel[i] |=> tag_q[i] == $past(iss_tag));
    a_r2_retag: assert property (@(posedge clk) disable iff (!rst_n)
      iss_we && iss_tag != '0 && iss_addr == AW'(i) && !snoop_hit[i]
      |=> tag_q[i] == $past(iss_tag) && $stable(data_q[i]));
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(bcast_live && cdb_tag == tag_q[i]) && !retag_sel[i]
      |=> $stable(tag_q[i]) && $stable(data_q[i]));
  end

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a == '0 |-> rd_data_a == '0 && rd_tag_a == '0);
  a_r9_zero_issue: assert property (@(posedge clk) disable iff (!rst_n)
    iss_we && iss_tag == '0 && !cdb_valid |=> $stable(tag_q) && $stable(data_q));
  a_r6_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a != '0 && bcast_live && tag_q[rd_addr_a] == cdb_tag
    |-> rd_data_a == cdb_data && rd_tag_a == '0);
  a_r5_stored_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a != '0 && !(bcast_live && tag_q[rd_addr_a] == cdb_tag)
    |-> rd_data_a == data_q[rd_addr_a] && rd_tag_a == tag_q[rd_addr_a]);
  a_r10_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_b != '0 && bcast_live && tag_q[rd_addr_b] == cdb_tag
    |-> rd_data_b == cdb_data && rd_tag_b == '0);
  a_r10_port_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_b == '0 |-> rd_data_b == '0 && rd_tag_b == '0);
endmodule

bind tag_rf tag_rf_chk #(.NREGS(NREGS), .DW(DW), .TW(TW)) u_chk (.*);

// File: tb/tag_rf_bench.sv
module tag_rf_bench;
  localparam int PERIOD = 10;
  localparam int NREGS  = 32;
  localparam int DW     = 32;
  localparam int TW     = 9;
  localparam int AW     = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_we = 0, cdb_valid = 0;
  logic [AW-1:0] iss_addr = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [TW-1:0] iss_tag = '0, cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic [DW-1:0] rd_data_a, rd_data_b;
  logic [TW-1:0] rd_tag_a, rd_tag_b;

  int checks = 0, fails = 0;
  logic [DW-1:0] m_data [NREGS];
  logic [TW-1:0] m_tag  [NREGS];

  always #(PERIOD/2) clk = ~clk;

  tag_rf u_tag_rf (.*);

  // Expected read result, taken from R5, R6 and R8
  function automatic logic [DW+TW-1:0] expect_rd(input int a);
    if (a == 0) return '0;
    if (cdb_valid && cdb_tag != 0 && cdb_tag == m_tag[a]) return {cdb_data, {TW{1'b0}}};
    return {m_data[a], m_tag[a]};
  endfunction

  task automatic check_port(input string req, input string port, input int a,
                            input logic [DW-1:0] d, input logic [TW-1:0] t);
    logic [DW+TW-1:0] e;
    e = expect_rd(a);
    checks++;
    if ({d, t} !== e) begin
      fails++;
      $display("FAIL %s port %s reg %0d: got data %h tag %h, expected data %h tag %h",
               req, port, a, d, t, e[DW+TW-1:TW], e[TW-1:0]);
    end
  endtask

  // One cycle: drive at the falling edge, check reads, then update the model after the edge
  task automatic cyc(input string req, input logic we, input int ia, input int it,
                     input logic cv, input int ct, input logic [DW-1:0] cd,
                     input int ra, input int rb);
    @(negedge clk);
    iss_we = we; iss_addr = AW'(ia); iss_tag = TW'(it);
    cdb_valid = cv; cdb_tag = TW'(ct); cdb_data = cd;
    rd_addr_a = AW'(ra); rd_addr_b = AW'(rb);
    #1;
    check_port(req, "A", ra, rd_data_a, rd_tag_a);
    check_port(req, "B", rb, rd_data_b, rd_tag_b);
    @(posedge clk);
    for (int k = 1; k < NREGS; k++) begin
      logic h;
      h = cv && ct != 0 && TW'(ct) == m_tag[k];
      if (h) m_data[k] = cd;
      if (we && it != 0 && ia == k) m_tag[k] = TW'(it);
      else if (h) m_tag[k] = '0;
    end
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < NREGS/2; k++) cyc(req, 0, 0, 0, 0, 0, '0, k, k + NREGS/2);
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(32'h9E37_79B9 * (k + 3)) ^ DW'(k << 20);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREGS; k++) begin m_data[k] = '0; m_tag[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    sweep("R1");
    // R8: register 0 refuses a tag and a broadcast
    cyc("R8", 1, 0, 9'h0AA, 0, 0, '0, 0, 0);
    cyc("R8", 0, 0, 0, 1, 9'h0AA, 32'hDEAD_BEEF, 0, 0);
    // R2: stamp every register with a distinct tag
    for (int k = 1; k < NREGS; k++) cyc("R2", 1, k, k * 7 + 1, 0, 0, '0, k, k - 1);
    sweep("R2");
    // R9: zero-tag issue changes nothing
    cyc("R9", 1, 5, 0, 0, 0, '0, 5, 6);
    cyc("R9", 0, 0, 0, 0, 0, '0, 5, 6);
    // R4: broadcasts that must not match
    cyc("R4", 0, 0, 0, 1, 9'h1FF, 32'h1111_1111, 8, 9);
    cyc("R4", 0, 0, 0, 1, 0, 32'h2222_2222, 8, 9);
    cyc("R4", 0, 0, 0, 0, 8 * 7 + 1, 32'h3333_3333, 8, 9);
    sweep("R4");
    // R10: port A bypasses while port B reads a different pending register
    cyc("R10", 0, 0, 0, 1, 1 * 7 + 1, pat(1), 1, 2);
    // R6 on port A and R3 captured value on port B, over every register
    for (int k = 2; k < NREGS; k++) cyc("R6", 0, 0, 0, 1, k * 7 + 1, pat(k), k, k - 1);
    sweep("R3");
    sweep("R5");
    // R7: new tag and matching broadcast in one cycle
    cyc("R7", 1, 3, 9'h100, 0, 0, '0, 3, 4);
    cyc("R7", 1, 3, 9'h101, 1, 9'h100, 32'hCAFE_F00D, 3, 4);
    cyc("R7", 0, 0, 0, 0, 0, '0, 3, 4);
    cyc("R7", 0, 0, 0, 1, 9'h101, 32'h0BAD_CAFE, 3, 4);
    cyc("R7", 0, 0, 0, 0, 0, '0, 3, 4);
    // R3: two registers waiting on one tag both capture
    cyc("R3", 1, 10, 9'h055, 0, 0, '0, 10, 11);
    cyc("R3", 1, 11, 9'h055, 0, 0, '0, 10, 11);
    cyc("R3", 0, 0, 0, 1, 9'h055, 32'h5A5A_A5A5, 10, 11);
    cyc("R3", 0, 0, 0, 0, 0, '0, 10, 11);
    // R10: both ports on the same pending register, then bypass on both
    cyc("R10", 1, 20, 9'h1F0, 0, 0, '0, 20, 20);
    cyc("R10", 0, 0, 0, 1, 9'h1F0, 32'h7777_0001, 20, 20);
    sweep("R5");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule